// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

This block is one countdown timer channel with a small register interface. Software sets a start value, picks a tick source and a counting mode, and enables the channel. The counter then steps down by one on each strobe from the chosen tick input. When it steps past zero, the channel raises a level interrupt. That interrupt stays high until software writes to the clear register.

In periodic mode, stepping past zero loads the start value into the counter again, so the channel interrupts every load+1 ticks. In free-running mode the counter wraps to all ones instead. The counter width is a parameter and is meant for 16-bit or 32-bit channels. The tick strobes come from logic outside the block. Each strobe is a one-cycle enable synchronous to `clk`.

The bus is a single-cycle request interface. A write takes effect at the clock edge where `bus_en` and `bus_we` are both high. A read request returns its data on `bus_rdata` after that edge. Bits [3:2] of the address select the register: 0x0 is load, 0x4 is the current count, 0x8 is control and 0xC is interrupt clear.

Top module: `tdt_channel`

## Requirements
- R1: After a synchronous reset, the load value, count, control word and `irq` are all zero.
- R2: The count and load registers are CNT_W bits wide. Writes keep only the low CNT_W bits, and reads zero-fill bits above CNT_W.
- R3: The count steps down by one on each selected tick while control bit 7 (run) is set. With run clear, or with no tick, the count holds.
- R4: Control bit 3 set selects `tick_fast`; bit 3 clear selects `tick_slow`. The unselected input has no effect.
- R5: With control bit 6 set (periodic), a tick at count zero loads the count from the load register and sets `irq`.
- R6: With control bit 6 clear (free-running), a tick at count zero wraps the count to all ones and sets `irq`.
- R7: `irq` stays high through further ticks until a write of any data to offset 0xC. That write drops it at the next edge.
- R8: If a clear write and an underflow fall in the same cycle, `irq` stays high.
- R9: A write to offset 0x0 copies the data into the count at the same edge. It takes priority over a tick in that cycle.
- R10: A control read returns only bits 7, 6 and 3; all other bits read zero. Writing zero to control stops counting.
- R11: Writes to the count register at offset 0x4 are ignored.
- R12: `bus_rdata` shows the addressed register one edge after a read request and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the channel |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| tick_fast | input | 1 | Fast tick strobe |
| tick_slow | input | 1 | Slow tick strobe |
| irq | output | 1 | Level interrupt, set on underflow |

## Verification
The hardest case to reach from the ports is a clear write that lands on the same edge as an underflow. The bench first steps the counter to exactly zero with single tick pulses. It then drives the clear write and a fast tick together in one cycle and checks that the interrupt survives and the count has reloaded. A second corner case is a load write that meets a live tick: the bench expects the written value, with no decrement. The unselected tick input is pulsed while the count is watched, which shows that the source-select bit really gates it.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
  // word index of each register (byte address bits [3:2])
  localparam logic [1:0] IDX_LOAD  = 2'd0;
  localparam logic [1:0] IDX_COUNT = 2'd1;
  localparam logic [1:0] IDX_CTRL  = 2'd2;
  localparam logic [1:0] IDX_CLEAR = 2'd3;

  // control word bit positions
  localparam int BIT_RUN    = 7;
  localparam int BIT_RELOAD = 6;
  localparam int BIT_FAST   = 3;

  typedef struct packed {
    logic run;
    logic reload;
    logic fast;
  } tdt_ctrl_t;
endpackage

// File: rtl/tdt_regs.sv
module tdt_regs
  import tdt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  count_i,
  output tdt_ctrl_t         ctrl_o,
  output logic [CNT_W-1:0]  load_o,
  output logic              load_wr_o,
  output logic              clr_wr_o,
  output logic [DATA_W-1:0] bus_rdata_o
);
  localparam int IDX_LSB = 2;
  localparam logic [DATA_W-1:0] CTRL_MASK =
    (DATA_W'(1) << BIT_RUN) | (DATA_W'(1) << BIT_RELOAD) | (DATA_W'(1) << BIT_FAST);

  logic [1:0]        widx;
  logic              wr, rd;
  tdt_ctrl_t         ctrl_q;
  logic [CNT_W-1:0]  load_q;
  logic [DATA_W-1:0] ctrl_word, rd_mux, rdata_q;

  assign widx      = bus_addr[IDX_LSB +: 2];
  assign wr        = bus_en && bus_we;
  assign rd        = bus_en && !bus_we;
  assign load_wr_o = wr && (widx == IDX_LOAD);
  assign clr_wr_o  = wr && (widx == IDX_CLEAR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      load_q <= '0;
    end else begin
      if (load_wr_o)
        load_q <= bus_wdata[CNT_W-1:0];
      if (wr && (widx == IDX_CTRL)) begin
        ctrl_q.run    <= bus_wdata[BIT_RUN];
        ctrl_q.reload <= bus_wdata[BIT_RELOAD];
        ctrl_q.fast   <= bus_wdata[BIT_FAST];
      end
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[BIT_RUN]    = ctrl_q.run;
    ctrl_word[BIT_RELOAD] = ctrl_q.reload;
    ctrl_word[BIT_FAST]   = ctrl_q.fast;
  end

  always_comb begin
    unique case (widx)
      IDX_LOAD:  rd_mux = DATA_W'(load_q);
      IDX_COUNT: rd_mux = DATA_W'(count_i);
      IDX_CTRL:  rd_mux = ctrl_word;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= rd_mux;
  end

  assign ctrl_o      = ctrl_q;
  assign load_o      = load_q;
  assign bus_rdata_o = rdata_q;

  // R10: reserved control bits never appear on the read bus
  p_ctrl_rsvd_r10: assert property (@(posedge clk) disable iff (rst)
    (rd && widx == IDX_CTRL) |=> ((bus_rdata_o & ~CTRL_MASK) == '0));
  // R12: read data only changes after a read request
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(bus_rdata_o));
endmodule

// File: rtl/tdt_counter.sv
module tdt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             reload,
  input  logic             fast,
  input  logic             tick_fast,
  input  logic             tick_slow,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_data,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count_o,
  output logic             underflow_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [CNT_W-1:0] count_q;
  logic             tick, step, at_zero;

  assign tick        = fast ? tick_fast : tick_slow;
  assign step        = run && tick && !load_wr;
  assign at_zero     = (count_q == '0);
  assign underflow_o = step && at_zero;

  always_ff @(posedge clk) begin
    if (rst)
      count_q <= '0;
    else if (load_wr)
      count_q <= load_data;
    else if (step)
      count_q <= at_zero ? (reload ? load_val : ALL_ONES) : count_q - 1'b1;
  end

  assign count_o = count_q;

  // R3: with no step and no load the count is frozen
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!(run && tick) && !load_wr) |=> $stable(count_o));
  // R5: periodic underflow brings back the load value
  p_reload_r5: assert property (@(posedge clk) disable iff (rst)
    (underflow_o && reload) |=> (count_o == $past(load_val)));
  // R6: free-running underflow wraps to all ones
  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (underflow_o && !reload) |=> (count_o == ALL_ONES));
  // R9: a load write always lands in the counter
  p_load_r9: assert property (@(posedge clk) disable iff (rst)
    load_wr |=> (count_o == $past(load_data)));
endmodule

// File: rtl/tdt_irq.sv
module tdt_irq (
  input  logic clk,
  input  logic rst,
  input  logic underflow,
  input  logic clr_wr,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst)            irq_q <= 1'b0;
    else if (underflow) irq_q <= 1'b1;
    else if (clr_wr)    irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  // R7: pending interrupt persists until cleared
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !clr_wr) |=> irq_o);
  // R7: a lone clear drops it
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !underflow) |=> !irq_o);
  // R8: underflow beats a simultaneous clear
  p_uf_wins_r8: assert property (@(posedge clk) disable iff (rst)
    underflow |=> irq_o);
endmodule

// File: rtl/tdt_channel.sv
module tdt_channel
  import tdt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_fast,
  input  logic              tick_slow,
  output logic              irq
);
  tdt_ctrl_t        ctrl;
  logic [CNT_W-1:0] load_val, count;
  logic             load_wr, clr_wr, underflow;

  tdt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .count_i(count),
    .ctrl_o(ctrl), .load_o(load_val), .load_wr_o(load_wr),
    .clr_wr_o(clr_wr), .bus_rdata_o(bus_rdata)
  );

  tdt_counter #(.CNT_W(CNT_W)) i_counter (
    .clk(clk), .rst(rst), .run(ctrl.run), .reload(ctrl.reload),
    .fast(ctrl.fast), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .load_wr(load_wr), .load_data(bus_wdata[CNT_W-1:0]),
    .load_val(load_val), .count_o(count), .underflow_o(underflow)
  );

  tdt_irq i_irq (
    .clk(clk), .rst(rst), .underflow(underflow), .clr_wr(clr_wr), .irq_o(irq)
  );

  // R1: outputs are quiet in the cycle after reset
  p_reset_r1: assert property (@(posedge clk) rst |=> (!irq && bus_rdata == '0));
endmodule

// File: tb/test_tdt_channel.sv
`timescale 1ns/1ps
module test_tdt_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_fast = 1'b0, tick_slow = 1'b0;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  tdt_channel #(.CNT_W(16), .DATA_W(32), .ADDR_W(4)) i_tdt_channel (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_fast(tick_fast), .tick_slow(tick_slow), .irq(irq)
  );

  typedef struct packed {
    logic [3:0]  waddr;
    logic [31:0] wdata;
    logic [3:0]  raddr;
    logic [31:0] exp;
  } vec_t;

  // write one register, read one register, compare
  localparam vec_t VECS [6] = '{
    '{4'h8, 32'hFFFF_FFFF, 4'h8, 32'h0000_00C8},  // R10 masked control
    '{4'h8, 32'h0000_0008, 4'h8, 32'h0000_0008},  // R10
    '{4'h0, 32'h1234_5678, 4'h0, 32'h0000_5678},  // R2 truncated load
    '{4'h4, 32'h0000_AAAA, 4'h4, 32'h0000_5678},  // R11 count ignores write, R9
    '{4'hC, 32'h0000_0000, 4'h8, 32'h0000_0008},  // R7 clear leaves control
    '{4'h8, 32'h0000_0000, 4'h8, 32'h0000_0000}   // R10 stop
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_en = 0; d = bus_rdata;
  endtask

  task automatic pulse(input logic fast);
    @(negedge clk); if (fast) tick_fast = 1; else tick_slow = 1;
    @(negedge clk); tick_fast = 0; tick_slow = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    bus_read(4'h0, rv); check("R1 load", rv, 0);
    bus_read(4'h4, rv); check("R1 count", rv, 0);
    bus_read(4'h8, rv); check("R1 ctrl", rv, 0);
    check("R1 irq", {31'b0, irq}, 0);

    foreach (VECS[i]) begin
      bus_write(VECS[i].waddr, VECS[i].wdata);
      bus_read(VECS[i].raddr, rv);
      check($sformatf("vector %0d", i), rv, VECS[i].exp);
    end

    // R12 read data holds without a request
    repeat (2) @(negedge clk);
    check("R12 hold", bus_rdata, 0);

    // periodic, fast source
    bus_write(4'h8, 32'h48);
    bus_write(4'h0, 32'd3);
    bus_write(4'h8, 32'hC8);
    pulse(0); pulse(0);
    bus_read(4'h4, rv); check("R4 slow ignored", rv, 3);
    pulse(1);
    bus_read(4'h4, rv); check("R3 decrement", rv, 2);
    pulse(1); pulse(1);
    bus_read(4'h4, rv); check("R3 at zero", rv, 0);
    check("R5 no irq yet", {31'b0, irq}, 0);
    pulse(1);
    bus_read(4'h4, rv); check("R5 reload", rv, 3);
    check("R5 irq", {31'b0, irq}, 1);
    pulse(1);
    check("R7 sticky", {31'b0, irq}, 1);
    bus_write(4'hC, 32'hDEAD_BEEF);
    check("R7 cleared", {31'b0, irq}, 0);

    // R8 clear and underflow together (count is 2 now)
    pulse(1); pulse(1);
    bus_read(4'h4, rv); check("R8 setup", rv, 0);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = 4'hC; tick_fast = 1;
    @(negedge clk); bus_en = 0; bus_we = 0; tick_fast = 0;
    check("R8 irq kept", {31'b0, irq}, 1);
    bus_read(4'h4, rv); check("R8 reloaded", rv, 3);
    bus_write(4'hC, 0);

    // R6 free-running wrap
    bus_write(4'h8, 32'h88);
    bus_write(4'h0, 32'd1);
    pulse(1); pulse(1);
    bus_read(4'h4, rv); check("R6 wrap", rv, 32'h0000_FFFF);
    check("R6 irq", {31'b0, irq}, 1);
    bus_write(4'hC, 0);

    // R4 slow source selected
    bus_write(4'h8, 32'h80);
    bus_write(4'h0, 32'd5);
    pulse(0);
    bus_read(4'h4, rv); check("R4 slow", rv, 4);
    pulse(1);
    bus_read(4'h4, rv); check("R4 fast ignored", rv, 4);

    // R9 load beats a tick in the same cycle
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = 4'h0; bus_wdata = 32'd9; tick_slow = 1;
    @(negedge clk); bus_en = 0; bus_we = 0; tick_slow = 0;
    bus_read(4'h4, rv); check("R9 load wins", rv, 9);

    // R10/R3 stop by writing zero
    bus_write(4'h8, 0);
    pulse(0); pulse(1);
    bus_read(4'h4, rv); check("R3 stopped", rv, 9);
    check("R7 no spurious irq", {31'b0, irq}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule